// File: doc/BRIEF.md
# Toggle-Clear Interrupt Aggregator for a Serial Peripheral Controller

This block gathers the interrupt sources of a serial peripheral controller into one interrupt line. Single-cycle event pulses set sticky bits in a status register: transmit register empty, transmit underrun, receive overrun and transmit FIFO half empty. Two receive FIFO levels, not-empty and full, are sampled on every clock. While either level is present its status bit is set again on each cycle. A bit that is set stays set until software writes a 1 to it, and that write toggles the bit.

Software uses a 32-bit register port with a single write strobe and a combinational read path. The port reaches four registers: a global enable, the status register, a per-bit enable register and a write-only soft-reset location. The interrupt output is a register. On each clock it loads the OR of the pending bits that are enabled, gated by the global enable bit, so it follows the register contents one clock later.

Top module: `irq_toggle_agg`

## Requirements
- R1: The global enable lives at byte offset 0x1C and holds only bit 31, so a read returns the written value ANDed with 0x8000_0000. The status register lives at 0x20. The enable register lives at 0x28 and keeps only the implemented status bits, so a read returns the written value ANDed with 0x0000_017C.
- R2: The implemented status bits are 2 (transmit empty pulse), 3 (transmit underrun pulse), 4 (receive full level), 5 (receive overrun pulse), 6 (transmit half empty pulse) and 8 (receive not-empty level). Every other status bit always reads 0.
- R3: A write to the status register XORs the write data into the implemented bits. A 1 clears a set bit and sets a clear bit; a 0 leaves the bit as it is.
- R4: A status bit that is set stays set through any number of cycles in which the status register is not written and no soft reset happens.
- R5: On every clock where the receive not-empty level is high, bit 8 is set, even when the same clock carries a toggle write to bit 8.
- R6: On every clock where the receive full level is high, bit 4 is set, even when the same clock carries a toggle write to bit 4.
- R7: The interrupt output on the clock after edge k equals 1 exactly when, before edge k, the status AND enable value was nonzero and global enable bit 31 was set.
- R8: After the asynchronous reset, the global enable, status and enable registers and the interrupt output are all 0.
- R9: Writing exactly 0x0000_000A to offset 0x40 clears all three registers on that clock, and events on that clock are dropped. Any other value written there has no effect. Reading offset 0x40 returns 0.
- R10: Reads of any offset not named above return 0, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr (combinational) |
| ev_tx_empty | input | 1 | Pulse: transmit register emptied |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_tx_half | input | 1 | Pulse: transmit FIFO half empty |
| lvl_rx_not_empty | input | 1 | Level: receive FIFO holds data |
| lvl_rx_full | input | 1 | Level: receive FIFO full |
| irq | output | 1 | Registered interrupt request |

## Verification
The event pulses are applied one at a time. This shows that each source lands on its own bit and on no other. Toggle writes are applied to set bits, to clear bits and to unimplemented bits, which separates an XOR from a plain clear or a plain store. Toggle writes are also made while a receive level is still high, which shows whether the level wins on the same clock. The interrupt line is stepped through every combination of pending, enabled and globally enabled, and soft-reset writes are made with both the correct key and a wrong key, so that gating errors and one-clock timing errors appear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Register selected by the address decoder
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_GIE  = 3'd1,
      SEL_STAT = 3'd2,
      SEL_IER  = 3'd3,
      SEL_SRST = 3'd4
   } reg_sel_e;

   localparam int unsigned DEF_DATA_W   = 32;
   localparam int unsigned DEF_ADDR_W   = 8;
   localparam int unsigned DEF_OFF_GIE  = 'h1C;
   localparam int unsigned DEF_OFF_STAT = 'h20;
   localparam int unsigned DEF_OFF_IER  = 'h28;
   localparam int unsigned DEF_OFF_SRST = 'h40;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned OFF_GIE  = DEF_OFF_GIE,
   parameter int unsigned OFF_STAT = DEF_OFF_STAT,
   parameter int unsigned OFF_IER  = DEF_OFF_IER,
   parameter int unsigned OFF_SRST = DEF_OFF_SRST
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
   localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);

   initial begin
      assert (OFF_GIE != OFF_STAT && OFF_GIE != OFF_IER && OFF_STAT != OFF_IER
              && OFF_SRST != OFF_GIE && OFF_SRST != OFF_STAT && OFF_SRST != OFF_IER)
         else $fatal(1, "register offsets must be distinct");
      assert (OFF_SRST < (1 << ADDR_W) && OFF_IER < (1 << ADDR_W))
         else $fatal(1, "offset does not fit ADDR_W");
   end

   always_comb begin
      unique case (addr)
         A_GIE:   sel = SEL_GIE;
         A_STAT:  sel = SEL_STAT;
         A_IER:   sel = SEL_IER;
         A_SRST:  sel = SEL_SRST;
         default: sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] set_vec,
   output logic [DATA_W-1:0] stat_q
);

   logic [DATA_W-1:0] tgl;
   assign tgl = wr ? wdata : '0;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stat_q[i] <= 1'b0;
            else if (clr) stat_q[i] <= 1'b0;
            else          stat_q[i] <= (stat_q[i] ^ tgl[i]) | set_vec[i];
         end
      end else begin : g_tie
         assign stat_q[i] = 1'b0;
      end
   end

   // R3
   toggle_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr && set_vec == '0) |=> stat_q == $past(stat_q ^ (wdata & IMPL_MASK)));

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !clr) |=> (stat_q & $past(stat_q)) == $past(stat_q));

   // R9
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> stat_q == '0);

endmodule

// File: rtl/irq_en_regs.sv
module irq_en_regs #(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       GIE_BIT   = 31,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_gie,
   input  logic              wr_ier,
   input  logic [DATA_W-1:0] wdata,
   output logic              gie_q,
   output logic [DATA_W-1:0] ier_q
);

   initial begin
      assert (GIE_BIT < DATA_W) else $fatal(1, "GIE_BIT outside data word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         ier_q <= '0;
      end else if (clr) begin
         gie_q <= 1'b0;
         ier_q <= '0;
      end else begin
         if (wr_gie) gie_q <= wdata[GIE_BIT];
         if (wr_ier) ier_q <= wdata & IMPL_MASK;
      end
   end

   // R9
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!gie_q && ier_q == '0));

   // R1
   gie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_gie && !clr) |=> gie_q == $past(wdata[GIE_BIT]));

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] stat,
   input  logic [DATA_W-1:0] ier,
   input  logic              gie,
   output logic              irq
);

   logic pend;
   assign pend = (|(stat & ier)) & gie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= pend;
   end

   // R7
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq == $past((|(stat & ier)) && gie));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |=> !irq);

endmodule

// File: rtl/irq_toggle_agg.sv
module irq_toggle_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned       DATA_W   = DEF_DATA_W,
   parameter int unsigned       ADDR_W   = DEF_ADDR_W,
   parameter int unsigned       OFF_GIE  = DEF_OFF_GIE,
   parameter int unsigned       OFF_STAT = DEF_OFF_STAT,
   parameter int unsigned       OFF_IER  = DEF_OFF_IER,
   parameter int unsigned       OFF_SRST = DEF_OFF_SRST,
   parameter logic [DATA_W-1:0] SRST_KEY = DATA_W'(32'h0000_000A),
   parameter int unsigned       GIE_BIT  = 31,
   parameter int unsigned       B_TXE    = 2,
   parameter int unsigned       B_TXU    = 3,
   parameter int unsigned       B_RXF    = 4,
   parameter int unsigned       B_RXO    = 5,
   parameter int unsigned       B_TXH    = 6,
   parameter int unsigned       B_RXNE   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_tx_empty,
   input  logic              ev_tx_underrun,
   input  logic              ev_rx_overrun,
   input  logic              ev_tx_half,
   input  logic              lvl_rx_not_empty,
   input  logic              lvl_rx_full,
   output logic              irq
);

   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] IMPL_MASK = (ONE << B_TXE) | (ONE << B_TXU) | (ONE << B_RXF)
                                           | (ONE << B_RXO) | (ONE << B_TXH) | (ONE << B_RXNE);

   initial begin
      assert (DATA_W >= 9 && DATA_W <= 64) else $fatal(1, "DATA_W out of range");
      assert (B_TXE < DATA_W && B_TXU < DATA_W && B_RXF < DATA_W && B_RXO < DATA_W
              && B_TXH < DATA_W && B_RXNE < DATA_W) else $fatal(1, "status bit outside word");
      assert ($countones(IMPL_MASK) == 6) else $fatal(1, "status bit positions collide");
   end

   reg_sel_e          sel;
   logic              srst_hit;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] ier_q;
   logic              gie_q;

   irq_addr_dec #(
      .ADDR_W(ADDR_W), .OFF_GIE(OFF_GIE), .OFF_STAT(OFF_STAT),
      .OFF_IER(OFF_IER), .OFF_SRST(OFF_SRST)
   ) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign srst_hit = reg_wr && (sel == SEL_SRST) && (reg_wdata == SRST_KEY);

   always_comb begin
      set_vec         = '0;
      set_vec[B_TXE]  = ev_tx_empty;
      set_vec[B_TXU]  = ev_tx_underrun;
      set_vec[B_RXF]  = lvl_rx_full;
      set_vec[B_RXO]  = ev_rx_overrun;
      set_vec[B_TXH]  = ev_tx_half;
      set_vec[B_RXNE] = lvl_rx_not_empty;
   end

   irq_status_reg #(
      .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
   ) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst_hit),
      .wr      (reg_wr && sel == SEL_STAT),
      .wdata   (reg_wdata),
      .set_vec (set_vec),
      .stat_q  (stat_q)
   );

   irq_en_regs #(
      .DATA_W(DATA_W), .GIE_BIT(GIE_BIT), .IMPL_MASK(IMPL_MASK)
   ) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (srst_hit),
      .wr_gie (reg_wr && sel == SEL_GIE),
      .wr_ier (reg_wr && sel == SEL_IER),
      .wdata  (reg_wdata),
      .gie_q  (gie_q),
      .ier_q  (ier_q)
   );

   irq_out_gen #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (stat_q),
      .ier   (ier_q),
      .gie   (gie_q),
      .irq   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_GIE:  reg_rdata[GIE_BIT] = gie_q;
         SEL_STAT: reg_rdata = stat_q;
         SEL_IER:  reg_rdata = ier_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R5
   rxne_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_rx_not_empty && !srst_hit) |=> stat_q[B_RXNE]);

   // R6
   rxfull_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_rx_full && !srst_hit) |=> stat_q[B_RXF]);

   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE || sel == SEL_SRST) |-> reg_rdata == '0);

endmodule

// File: tb/irq_toggle_agg_tb.sv
module irq_toggle_agg_tb;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned WDOG_LIMIT = 5000;
   localparam logic [31:0] MASK       = 32'h0000_017C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        ev_tx_empty = 1'b0, ev_tx_underrun = 1'b0, ev_rx_overrun = 1'b0, ev_tx_half = 1'b0;
   logic        lvl_rx_not_empty = 1'b0, lvl_rx_full = 1'b0;
   logic        irq;

   int    n_checks = 0;
   int    n_errors = 0;
   int    n_cycles = 0;
   string tag = "R8";

   // reference state
   logic [31:0] m_gie = 0, m_stat = 0, m_ier = 0;
   logic        m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_toggle_agg u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_tx_empty(ev_tx_empty), .ev_tx_underrun(ev_tx_underrun),
      .ev_rx_overrun(ev_rx_overrun), .ev_tx_half(ev_tx_half),
      .lvl_rx_not_empty(lvl_rx_not_empty), .lvl_rx_full(lvl_rx_full),
      .irq(irq)
   );

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h1C:   return m_gie;
         8'h20:   return m_stat;
         8'h28:   return m_ier;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk32(input string t, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", t, got, exp);
      end
   endtask

   task automatic compare();
      chk32({tag, " rdata"}, reg_rdata, model_read(reg_addr));
      chk32({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
   endtask

   // One clock: reference update from inputs seen at the edge, check at the next falling edge
   task automatic cyc();
      logic [31:0] n_gie, n_stat, n_ier, ev;
      logic        n_irq;
      @(posedge clk);
      ev = ({31'h0, ev_tx_empty} << 2) | ({31'h0, ev_tx_underrun} << 3) |
           ({31'h0, lvl_rx_full} << 4) | ({31'h0, ev_rx_overrun} << 5) |
           ({31'h0, ev_tx_half} << 6) | ({31'h0, lvl_rx_not_empty} << 8);
      n_irq = ((m_stat & m_ier) != 0) && m_gie[31];
      n_gie = m_gie; n_ier = m_ier;
      n_stat = ((m_stat ^ ((reg_wr && reg_addr == 8'h20) ? reg_wdata : 32'h0)) | ev) & MASK;
      if (reg_wr && reg_addr == 8'h1C) n_gie = reg_wdata & 32'h8000_0000;
      if (reg_wr && reg_addr == 8'h28) n_ier = reg_wdata & MASK;
      if (reg_wr && reg_addr == 8'h40 && reg_wdata == 32'h0000_000A) begin
         n_gie = 0; n_stat = 0; n_ier = 0;
      end
      @(negedge clk);
      m_gie = n_gie; m_stat = n_stat; m_ier = n_ier; m_irq = n_irq;
      compare();
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      reg_addr = a;
      cyc();
   endtask

   always @(posedge clk) begin
      n_cycles++;
      if (n_cycles > WDOG_LIMIT) begin
         n_errors++;
         $display("FAIL watchdog: got %0d cycles expected at most %0d", n_cycles, WDOG_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      reg_addr = 8'h20;
      compare();
      rst_n = 1'b1;
      rd(8'h1C); rd(8'h20); rd(8'h28);

      // R1: offsets and stored widths
      tag = "R1";
      wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C);
      wr(8'h28, 32'hFFFF_FFFF); rd(8'h28);
      wr(8'h1C, 32'h7FFF_FFFF); rd(8'h1C);
      wr(8'h28, 32'h0); rd(8'h28);

      // R10: unmapped offsets
      tag = "R10";
      wr(8'h24, 32'hFFFF_FFFF); rd(8'h24); rd(8'h1C); rd(8'h20); rd(8'h28);
      rd(8'h40);

      // R2: each pulse source on its own bit
      tag = "R2";
      reg_addr = 8'h20;
      ev_tx_empty = 1'b1;    cyc(); ev_tx_empty = 1'b0;    cyc();
      wr(8'h20, 32'h0000_0004); rd(8'h20);
      ev_tx_underrun = 1'b1; cyc(); ev_tx_underrun = 1'b0; cyc();
      ev_rx_overrun = 1'b1;  cyc(); ev_rx_overrun = 1'b0;  cyc();
      ev_tx_half = 1'b1;     cyc(); ev_tx_half = 1'b0;     cyc();

      // R4: sticky across idle cycles
      tag = "R4";
      repeat (6) rd(8'h20);

      // R3: XOR semantics
      tag = "R3";
      wr(8'h20, 32'h0000_0008); rd(8'h20);
      wr(8'h20, 32'h0000_0004); rd(8'h20);
      wr(8'h20, 32'hFFFF_FE83); rd(8'h20);
      wr(8'h20, 32'h0000_0000); rd(8'h20);
      wr(8'h20, 32'h0000_0064); rd(8'h20);

      // R5: receive not-empty level wins over toggle
      tag = "R5";
      lvl_rx_not_empty = 1'b1;
      rd(8'h20);
      wr(8'h20, 32'h0000_0100); rd(8'h20);
      wr(8'h20, 32'h0000_0100);
      lvl_rx_not_empty = 1'b0;
      rd(8'h20);
      wr(8'h20, 32'h0000_0100); rd(8'h20);

      // R6: receive full level wins over toggle
      tag = "R6";
      lvl_rx_full = 1'b1;
      rd(8'h20);
      wr(8'h20, 32'h0000_0010); rd(8'h20);
      lvl_rx_full = 1'b0;
      rd(8'h20);
      wr(8'h20, 32'h0000_0010); rd(8'h20);

      // R7: output gating and one-clock delay
      tag = "R7";
      wr(8'h20, 32'h0000_0004); rd(8'h20);
      wr(8'h28, 32'h0000_0004); rd(8'h20); rd(8'h20);
      wr(8'h1C, 32'h8000_0000); rd(8'h20); rd(8'h20);
      wr(8'h28, 32'h0000_0008); rd(8'h20); rd(8'h20);
      wr(8'h28, 32'h0000_000C); rd(8'h20); rd(8'h20);
      wr(8'h1C, 32'h0000_0000); rd(8'h20); rd(8'h20);
      wr(8'h1C, 32'h8000_0000); rd(8'h20);
      wr(8'h20, 32'h0000_0004); rd(8'h20); rd(8'h20);
      ev_tx_underrun = 1'b1; cyc(); ev_tx_underrun = 1'b0; cyc(); rd(8'h20);

      // R9: soft reset with wrong and right key
      tag = "R9";
      wr(8'h28, 32'h0000_017C);
      ev_tx_half = 1'b1; cyc(); ev_tx_half = 1'b0;
      wr(8'h40, 32'h0000_000B); rd(8'h1C); rd(8'h20); rd(8'h28);
      wr(8'h40, 32'h0000_010A); rd(8'h20);
      lvl_rx_not_empty = 1'b1;
      wr(8'h40, 32'h0000_000A);
      rd(8'h1C); rd(8'h28); rd(8'h20);
      lvl_rx_not_empty = 1'b0;
      rd(8'h20); rd(8'h20);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule